// File: doc/BRIEF.md
# Two-Stage Macro-Op Issue Scheduler

This block is the issue queue of an out-of-order core whose front end fuses dependent instruction pairs into macro-ops. Each macro-op, whether a lone operation or a fused head/tail pair, takes one queue entry. An entry can wait on two source tags. The queue is split into a wakeup stage and a select stage, one clock each. A granted entry's destination tag wakes its consumers in the cycle its grant is visible. Consumers then compete in select on the next cycle. Select picks the oldest ready entry in each of three lanes.

Because the fused head is always a single-cycle operation, a consumer that issues two cycles after its producer still lines up with the producer's result. A macro-op whose head is not single-cycle is marked at dispatch. It wakes its consumers one cycle later, through a separate broadcast slot. A flush empties the queue and the issue and broadcast pipeline in one edge.

Top module: `mops_sched`

## Requirements
- R1: After synchronous reset, `iss_valid` and `bcast_valid` are all zero and `full` is low.
- R2: An op dispatched with both ready flags set issues on the second rising edge after its dispatch edge, and not on the first. Issue sets `iss_valid[lane]`, and `iss_dst[lane*TAG_W +: TAG_W]` carries the op's destination tag.
- R3: Within one lane, when several entries are ready, the one dispatched earliest issues first, whatever queue slot it occupies. One entry issues per lane per cycle.
- R4: Lanes are selected independently. `disp_lane` values 0, 1 and 2 name the lanes, up to three ops issue in the same cycle, and each op issues only on the lane it was dispatched to.
- R5: For an op dispatched with `disp_head1c`=1 that issues in cycle c, its tag is on broadcast slot `lane` in cycle c+1. A consumer waiting on that tag issues no earlier than cycle c+2, and exactly then when nothing else contends.
- R6: For an op dispatched with `disp_head1c`=0 that issues in cycle c, its tag is on broadcast slot `LANES+lane` in cycle c+2 and not on slot `lane`. A waiting consumer issues no earlier than cycle c+3.
- R7: An entry waiting on two tags issues only after both tags have been woken.
- R8: A source dispatched as not ready, whose tag is being woken in the dispatch cycle itself, is captured as ready.
- R9: The queue holds ENTRIES ops (16 by default). `full` is high exactly when all are occupied, and a dispatch offered while `full` is high is discarded and never issues.
- R10: A flush empties every entry in one edge and clears the issue and broadcast outputs, so `full` is low on the next cycle. A dispatch offered in the flush cycle is discarded.
- R11: Every accepted op issues exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop all queued and in-flight ops |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_lane | input | LANE_W | Issue lane of the op (0..2) |
| disp_src0 | input | TAG_W | First source tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1 | input | TAG_W | Second source tag |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_dst | input | TAG_W | Destination tag |
| disp_head1c | input | 1 | Head is a single-cycle operation |
| full | output | 1 | No free entry; dispatch is discarded |
| iss_valid | output | LANES | Grant per lane |
| iss_dst | output | LANES*TAG_W | Destination tag of each lane's grant |
| bcast_valid | output | 2*LANES | Broadcast slots: fast per lane, then slow per lane |
| bcast_tag | output | 2*LANES*TAG_W | Tag on each broadcast slot |

## Verification
The hardest case to reach from the ports is age order that disagrees with slot order. Free slots are filled lowest first, so a younger op lands in a lower slot only after an older op has drained and left a hole. The stimulus creates that hole, parks two consumers of one lane behind a shared tag, then releases the tag. The dispatch-cycle capture of R8 is also hit deliberately, by offering a consumer in exactly the cycle its producer's grant is visible. A random phase with chained dependencies checks lanes, exactly-once issue and the minimum issue distance to every producer.

// File: rtl/mops_pkg.sv
package mops_pkg;
    localparam int TAG_W      = 7;
    localparam int LANES      = 3;
    localparam int LANE_W     = 2;
    localparam int WAKE_PORTS = 2 * LANES;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic  vld;
        logic  h1c;
        lane_t lane;
        logic  r0;
        logic  r1;
        tag_t  s0;
        tag_t  s1;
        tag_t  dst;
    } iq_ent_t;
endpackage

// File: rtl/mops_wakeup.sv
module mops_wakeup
    import mops_pkg::*;
#(
    parameter int NW = WAKE_PORTS
) (
    input  tag_t                tag,
    input  logic [NW-1:0]       wv,
    input  logic [NW*TAG_W-1:0] wt,
    output logic                hit
);
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NW; k++) begin
            if (wv[k] && (wt[k*TAG_W +: TAG_W] == tag)) hit = 1'b1;
        end
    end
endmodule

// File: rtl/mops_alloc.sv
module mops_alloc #(
    parameter int N = 16
) (
    input  logic [N-1:0] busy,
    output logic [N-1:0] pick,
    output logic         full
);
    logic found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!busy[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    assign full = &busy;
endmodule

// File: rtl/mops_select.sv
module mops_select
    import mops_pkg::*;
#(
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              alloc_en,
    input  logic [N-1:0]      alloc_pick,
    input  logic [N-1:0]      valid,
    input  logic [N-1:0]      req,
    input  logic [N*LANE_W-1:0] lane_flat,
    output logic [N-1:0]      grant
);
    // older[i][j] set: entry i was allocated before entry j
    logic [N-1:0] older [N];

    always_ff @(posedge clk) begin
        if (alloc_en) begin
            for (int k = 0; k < N; k++) begin
                if (alloc_pick[k]) begin
                    older[k] <= '0;
                    for (int j = 0; j < N; j++) begin
                        if (j != k) older[j][k] <= valid[j];
                    end
                end
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_pick
        logic blk;
        always_comb begin
            blk = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && older[j][i] &&
                    lane_flat[j*LANE_W +: LANE_W] == lane_flat[i*LANE_W +: LANE_W])
                    blk = 1'b1;
            end
            grant[i] = req[i] & ~blk;
        end
    end
endmodule

// File: rtl/mops_sched.sv
module mops_sched
    import mops_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         disp_valid,
    input  logic [LANE_W-1:0]            disp_lane,
    input  logic [TAG_W-1:0]             disp_src0,
    input  logic                         disp_src0_rdy,
    input  logic [TAG_W-1:0]             disp_src1,
    input  logic                         disp_src1_rdy,
    input  logic [TAG_W-1:0]             disp_dst,
    input  logic                         disp_head1c,
    output logic                         full,
    output logic [LANES-1:0]             iss_valid,
    output logic [LANES*TAG_W-1:0]       iss_dst,
    output logic [2*LANES-1:0]           bcast_valid,
    output logic [2*LANES*TAG_W-1:0]     bcast_tag
);
    iq_ent_t ents [ENTRIES];

    logic [ENTRIES-1:0]        busy, req, pick, grant, hit0, hit1;
    logic [ENTRIES*LANE_W-1:0] lane_flat;
    logic                      alloc_en, dhit0, dhit1;

    logic [LANES-1:0]          iss_h1c, slow_v, nxt_v, nxt_h;
    logic [LANES*TAG_W-1:0]    slow_tag, nxt_dst;
    logic [WAKE_PORTS-1:0]     wv;
    logic [WAKE_PORTS*TAG_W-1:0] wt;

    // wakeup stage: fast slots from the grant register, slow slots one cycle later
    assign wv = {slow_v, iss_valid & iss_h1c};
    assign wt = {slow_tag, iss_dst};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign busy[i] = ents[i].vld;
        assign req[i]  = ents[i].vld & ents[i].r0 & ents[i].r1;
        assign lane_flat[i*LANE_W +: LANE_W] = ents[i].lane;

        mops_wakeup #(.NW(WAKE_PORTS)) u_w0 (.tag(ents[i].s0), .wv(wv), .wt(wt), .hit(hit0[i]));
        mops_wakeup #(.NW(WAKE_PORTS)) u_w1 (.tag(ents[i].s1), .wv(wv), .wt(wt), .hit(hit1[i]));
    end

    mops_wakeup #(.NW(WAKE_PORTS)) u_dw0 (.tag(disp_src0), .wv(wv), .wt(wt), .hit(dhit0));
    mops_wakeup #(.NW(WAKE_PORTS)) u_dw1 (.tag(disp_src1), .wv(wv), .wt(wt), .hit(dhit1));

    mops_alloc #(.N(ENTRIES)) u_alloc (.busy(busy), .pick(pick), .full(full));

    assign alloc_en = disp_valid & ~full & ~flush;

    mops_select #(.N(ENTRIES)) u_sel (
        .clk(clk), .alloc_en(alloc_en), .alloc_pick(pick), .valid(busy),
        .req(req), .lane_flat(lane_flat), .grant(grant)
    );

    // fold entry grants into per-lane issue slots
    always_comb begin
        nxt_v   = '0;
        nxt_h   = '0;
        nxt_dst = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (grant[i] && ents[i].lane == lane_t'(l)) begin
                    nxt_v[l] = 1'b1;
                    nxt_h[l] = ents[i].h1c;
                    nxt_dst[l*TAG_W +: TAG_W] = ents[i].dst;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst || flush) begin
                ents[i].vld <= 1'b0;
            end else if (alloc_en && pick[i]) begin
                ents[i] <= '{vld: 1'b1, h1c: disp_head1c, lane: disp_lane,
                             r0: disp_src0_rdy | dhit0, r1: disp_src1_rdy | dhit1,
                             s0: disp_src0, s1: disp_src1, dst: disp_dst};
            end else if (grant[i]) begin
                ents[i].vld <= 1'b0;
            end else begin
                ents[i].r0 <= ents[i].r0 | hit0[i];
                ents[i].r1 <= ents[i].r1 | hit1[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            iss_valid   <= '0;
            iss_h1c     <= '0;
            iss_dst     <= '0;
            slow_v      <= '0;
            slow_tag    <= '0;
            bcast_valid <= '0;
            bcast_tag   <= '0;
        end else begin
            iss_valid   <= nxt_v;
            iss_h1c     <= nxt_h;
            iss_dst     <= nxt_dst;
            slow_v      <= iss_valid & ~iss_h1c;
            slow_tag    <= iss_dst;
            bcast_valid <= wv;
            bcast_tag   <= wt;
        end
    end
endmodule

// File: rtl/mops_sched_chk.sv
module mops_sched_chk
    import mops_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     flush,
    input logic                     disp_valid,
    input logic                     full,
    input logic [LANES-1:0]         iss_valid,
    input logic [LANES*TAG_W-1:0]   iss_dst,
    input logic [2*LANES-1:0]       bcast_valid,
    input logic [2*LANES*TAG_W-1:0] bcast_tag
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (iss_valid == '0 && bcast_valid == '0 && !full));

    p_flush_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (iss_valid == '0 && bcast_valid == '0 && !full));

    p_full_from_disp_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(disp_valid));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        p_fast_bcast_r5: assert property (@(posedge clk) disable iff (rst)
            bcast_valid[l] |-> ($past(iss_valid[l]) &&
                bcast_tag[l*TAG_W +: TAG_W] == $past(iss_dst[l*TAG_W +: TAG_W])));

        p_slow_bcast_r6: assert property (@(posedge clk) disable iff (rst)
            bcast_valid[LANES+l] |-> ($past(iss_valid[l], 2) &&
                bcast_tag[(LANES+l)*TAG_W +: TAG_W] == $past(iss_dst[l*TAG_W +: TAG_W], 2)));
    end
endmodule

bind mops_sched mops_sched_chk u_chk (
    .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid), .full(full),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .bcast_valid(bcast_valid), .bcast_tag(bcast_tag)
);

// File: tb/mops_sched_bench.sv
module mops_sched_bench;
    import mops_pkg::*;

    localparam int N    = 16;
    localparam int NOPS = 100;

    logic clk = 1'b0;
    logic rst, flush, disp_valid, disp_src0_rdy, disp_src1_rdy, disp_head1c;
    logic [LANE_W-1:0] disp_lane;
    logic [TAG_W-1:0]  disp_src0, disp_src1, disp_dst;
    logic full;
    logic [LANES-1:0]             iss_valid;
    logic [LANES*TAG_W-1:0]       iss_dst;
    logic [2*LANES-1:0]           bcast_valid;
    logic [2*LANES*TAG_W-1:0]     bcast_tag;

    always #4 clk = ~clk;

    mops_sched #(.ENTRIES(N)) u_mops_sched (
        .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid), .disp_lane(disp_lane),
        .disp_src0(disp_src0), .disp_src0_rdy(disp_src0_rdy), .disp_src1(disp_src1),
        .disp_src1_rdy(disp_src1_rdy), .disp_dst(disp_dst), .disp_head1c(disp_head1c),
        .full(full), .iss_valid(iss_valid), .iss_dst(iss_dst),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag)
    );

    int vecs = 0, errs = 0, cyc = 0;
    bit mon_on = 0, done = 0;
    int stray = 0;
    int op_lane [NOPS], op_h [NOPS], dep0 [NOPS], dep1 [NOPS];
    int disp_at [NOPS], iss_at [NOPS], iss_ln [NOPS], dbl [NOPS];

    function automatic int itag(int l);
        return int'(iss_dst[l*TAG_W +: TAG_W]);
    endfunction

    function automatic int btag(int s);
        return int'(bcast_tag[s*TAG_W +: TAG_W]);
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic monitor();
        for (int l = 0; l < LANES; l++) begin
            if (iss_valid[l]) begin
                int t = itag(l);
                if (t >= 1 && t <= NOPS) begin
                    if (iss_at[t-1] >= 0) dbl[t-1]++;
                    else begin
                        iss_at[t-1] = cyc;
                        iss_ln[t-1] = l;
                    end
                end else stray++;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
        if (mon_on) monitor();
    endtask

    task automatic send(input int ln, input int s0, input bit r0, input int s1, input bit r1,
                        input int dst, input bit h1c);
        disp_valid    = 1'b1;
        disp_lane     = LANE_W'(ln);
        disp_src0     = TAG_W'(s0);
        disp_src0_rdy = r0;
        disp_src1     = TAG_W'(s1);
        disp_src1_rdy = r1;
        disp_dst      = TAG_W'(dst);
        disp_head1c   = h1c;
    endtask

    task automatic idle();
        disp_valid = 1'b0;
    endtask

    function automatic bit rdy_now(int p);
        if (p < 0) return 1'b1;
        if (iss_at[p] < 0) return 1'b0;
        return (iss_at[p] + (op_h[p] != 0 ? 0 : 1)) < cyc;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R11: watchdog actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; flush = 1'b0;
        send(0, 0, 1, 0, 1, 0, 1); idle();
        for (int i = 0; i < NOPS; i++) begin iss_at[i] = -1; dbl[i] = 0; end
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 iss_valid", int'(iss_valid), 0);
        chk("R1 bcast_valid", int'(bcast_valid), 0);
        chk("R1 full", int'(full), 0);

        // R2 / R11 single ready op on lane 1
        send(1, 0, 1, 0, 1, 5, 1); tick(); idle();
        chk("R2 not on first edge", int'(iss_valid), 0);
        tick();
        chk("R2 issue lane", int'(iss_valid), 3'b010);
        chk("R2 issue tag", itag(1), 5);
        tick();
        chk("R11 issued once", int'(iss_valid), 0);
        chk("R5 fast slot", int'(bcast_valid), 6'b000010);
        chk("R5 fast tag", btag(1), 5);
        tick();
        chk("R6 no slow slot for fast head", int'(bcast_valid), 0);

        // R5 fast dependent
        send(0, 0, 1, 0, 1, 10, 1); tick();
        send(1, 10, 0, 0, 1, 11, 1); tick(); idle();
        chk("R5 producer", int'(iss_valid), 3'b001);
        tick();
        chk("R5 consumer not at c+1", int'(iss_valid), 0);
        chk("R5 bcast tag", btag(0), 10);
        tick();
        chk("R5 consumer at c+2", int'(iss_valid), 3'b010);
        chk("R5 consumer tag", itag(1), 11);
        repeat (2) tick();

        // R6 slow head
        send(0, 0, 1, 0, 1, 12, 0); tick();
        send(2, 0, 1, 12, 0, 13, 1); tick(); idle();
        chk("R6 producer", int'(iss_valid), 3'b001);
        tick();
        chk("R6 no fast slot", int'(bcast_valid), 0);
        tick();
        chk("R6 slow slot", int'(bcast_valid), 6'b001000);
        chk("R6 slow tag", btag(LANES), 12);
        chk("R6 consumer not at c+2", int'(iss_valid), 0);
        tick();
        chk("R6 consumer at c+3", int'(iss_valid), 3'b100);
        chk("R6 consumer tag", itag(2), 13);
        repeat (2) tick();

        // R8 capture in the producer's grant cycle
        send(1, 0, 1, 0, 1, 14, 1); tick(); idle();
        tick();
        chk("R8 producer", int'(iss_valid), 3'b010);
        send(0, 14, 0, 0, 1, 15, 1); tick(); idle();
        tick();
        chk("R8 captured consumer", int'(iss_valid), 3'b001);
        chk("R8 consumer tag", itag(0), 15);
        repeat (2) tick();

        // R3 age order against slot order
        send(0, 0, 1, 0, 1, 30, 1); tick();
        send(2, 70, 0, 0, 1, 31, 1); tick();
        send(2, 70, 0, 0, 1, 32, 1); tick();
        send(1, 0, 1, 0, 1, 70, 1); tick(); idle();
        tick();
        chk("R3 producer", int'(iss_valid), 3'b010);
        tick(); tick();
        chk("R3 one per lane", int'(iss_valid), 3'b100);
        chk("R3 older first", itag(2), 31);
        tick();
        chk("R3 younger next", int'(iss_valid), 3'b100);
        chk("R3 younger tag", itag(2), 32);
        repeat (2) tick();

        // R4 three lanes in one cycle
        send(0, 80, 0, 0, 1, 81, 1); tick();
        send(1, 80, 0, 0, 1, 82, 1); tick();
        send(2, 0, 1, 80, 0, 83, 1); tick();
        send(0, 0, 1, 0, 1, 80, 1); tick(); idle();
        tick();
        chk("R4 producer", int'(iss_valid), 3'b001);
        tick(); tick();
        chk("R4 all lanes", int'(iss_valid), 3'b111);
        chk("R4 lane0 tag", itag(0), 81);
        chk("R4 lane1 tag", itag(1), 82);
        chk("R4 lane2 tag", itag(2), 83);
        repeat (2) tick();

        // R7 two waiting sources
        send(1, 90, 0, 91, 0, 92, 1); tick();
        send(0, 0, 1, 0, 1, 90, 1); tick();
        send(2, 0, 1, 0, 1, 91, 1); tick(); idle();
        tick(); tick();
        chk("R7 one source only", int'(iss_valid[1]), 0);
        tick();
        chk("R7 both sources", int'(iss_valid), 3'b010);
        chk("R7 tag", itag(1), 92);
        repeat (2) tick();

        // R9 capacity
        for (int k = 0; k < N; k++) begin
            if (k == N - 1) chk("R9 not full one short", int'(full), 0);
            send(0, 100, 0, 0, 1, 101 + k, 1); tick();
        end
        chk("R9 full", int'(full), 1);
        send(1, 0, 1, 0, 1, 120, 1); tick(); idle();
        chk("R9 still full", int'(full), 1);
        tick(); tick();
        chk("R9 dropped op silent", int'(iss_valid), 0);

        // R10 flush
        flush = 1'b1; send(1, 0, 1, 0, 1, 121, 1); tick(); flush = 1'b0; idle();
        chk("R10 full cleared", int'(full), 0);
        chk("R10 iss cleared", int'(iss_valid), 0);
        send(0, 0, 1, 0, 1, 100, 1); tick(); idle();
        tick();
        chk("R10 producer after flush", int'(iss_valid), 3'b001);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R10 flushed entries gone", int'(iss_valid), 0);
        end
        send(2, 0, 1, 0, 1, 122, 1); tick(); idle();
        flush = 1'b1; tick(); flush = 1'b0;
        chk("R10 in-flight grant cleared", int'(iss_valid), 0);
        chk("R10 bcast cleared", int'(bcast_valid), 0);
        tick();
        chk("R10 op not issued later", int'(iss_valid), 0);
        chk("R10 no bcast later", int'(bcast_valid), 0);

        // random dependency chains
        for (int i = 0; i < NOPS; i++) begin
            op_lane[i] = int'($urandom % 3);
            op_h[i]    = int'($urandom % 2);
            dep0[i]    = (i > 0 && ($urandom % 2) == 1) ? i - 1 - int'($urandom % ((i < 6) ? i : 6)) : -1;
            dep1[i]    = (i > 0 && ($urandom % 3) == 1) ? i - 1 - int'($urandom % ((i < 6) ? i : 6)) : -1;
        end
        mon_on = 1;
        begin
            int i = 0;
            while (i < NOPS) begin
                if ($urandom % 4 == 0) begin
                    idle(); tick();
                end else begin
                    send(op_lane[i], dep0[i] >= 0 ? dep0[i] + 1 : 0, rdy_now(dep0[i]),
                         dep1[i] >= 0 ? dep1[i] + 1 : 0, rdy_now(dep1[i]), i + 1, op_h[i] != 0);
                    if (!full) begin
                        disp_at[i] = cyc + 1;
                        i++;
                    end
                    tick();
                end
            end
        end
        idle();
        repeat (80) tick();
        mon_on = 0;
        for (int i = 0; i < NOPS; i++) begin
            chk("R11 issued", int'(iss_at[i] >= 0), 1);
            chk("R11 exactly once", dbl[i], 0);
            chk("R4 lane", iss_ln[i], op_lane[i]);
            chk("R2 latency", int'(iss_at[i] >= disp_at[i] + 1), 1);
            if (dep0[i] >= 0)
                chk(op_h[dep0[i]] != 0 ? "R5 dependent distance" : "R6 dependent distance",
                    int'(iss_at[i] >= iss_at[dep0[i]] + (op_h[dep0[i]] != 0 ? 2 : 3)), 1);
            if (dep1[i] >= 0)
                chk("R7 second source distance",
                    int'(iss_at[i] >= iss_at[dep1[i]] + (op_h[dep1[i]] != 0 ? 2 : 3)), 1);
        end
        chk("R4 no stray issue", stray, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule